// File: doc/BRIEF.md
# Inter-Port Semaphore Flag Unit

This unit holds a small bank of one-bit lock tokens that two independent ports share. Software on either side claims a token by writing a zero to it and gives it back by writing a one. A claimed token reads as zero only to the port that holds it; the other port reads a one and knows the resource is taken. A port addresses the tokens with its semaphore select asserted and its memory chip select inactive, and the three lowest address bits pick one of eight tokens. The shared RAM array, busy arbitration and interrupt logic sit next to this unit and are not part of it.

Each port follows a strobe model: a write is armed while the read/write line is low with the semaphore selected, and it takes effect in the cycle where the line returns high. A read returns the chosen token on every bit of the data bus. A port whose claim finds the token held is queued, and it receives the token one cycle after the holder gives it back. When both ports claim a free token in the same cycle, the left port wins.

Top module: `semflag_unit`

## Requirements
- R1: After reset every token is free and reads as 1 from both ports.
- R2: Address bits [2:0] choose the token; all higher address bits have no effect on which token is read or written.
- R3: A write arms while semaphore select is low, chip select is high and read/write is 0; it commits at the clock edge of the first cycle with read/write back at 1, using the address and data bit 0 captured in the last low cycle. Data bits 17:1 are ignored.
- R4: When semaphore select is low, chip select high, read/write 1 and output enable low, the read data drive enable is 1 and all 18 read data bits equal the chosen token as seen by this port; otherwise the drive enable is 0 and read data is all zeros.
- R5: Writing 0 to a token that the other port does not hold grants it: the writer then reads 0 and the other port reads 1.
- R6: Writing 0 to a token the other port holds queues the request; when the holder writes 1 the token is free (reads 1 to both) after that commit edge, and the queued port holds it one edge later.
- R7: Writing 1 to a token the port does not hold leaves ownership unchanged and withdraws that port's own queued request.
- R8: If both ports request the same free token at the same edge, the left port is granted and the right request is queued.
- R9: Semaphore select and chip select both low in a cycle is illegal: no token changes for that port, any armed write is dropped, and the error output is high for exactly one cycle, the cycle after the first illegal cycle of a run.
- R10: If a port leaves the semaphore (select high) while read/write is still low, the strobe is abandoned and nothing is committed when read/write later rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left memory chip select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 13 | Left address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data |
| l_rdata_oe | output | 1 | Left read data drive enable |
| l_err | output | 1 | Left illegal-access pulse |
| r_ce_n | input | 1 | Right memory chip select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 13 | Right address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data |
| r_rdata_oe | output | 1 | Right read data drive enable |
| r_err | output | 1 | Right illegal-access pulse |

## Verification
A corrupted owner or queue bit is visible the moment either port reads the affected token, since reads are combinational from the stored state: a wrong grant shows as two ports disagreeing with the expected 0/1 pair in the same cycle. A lost queued request shows one cycle after a release, when the waiting port still reads 1. A bad strobe tracker shows as a token changing one edge early, one edge late, or not at all, and is caught on the first read after the expected commit edge.

// File: rtl/semflag_pkg.sv
// Shared types for the semaphore flag unit.
package semflag_pkg;
    // Holder of one token.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/semflag_port.sv
// One access port of the semaphore unit.
// Decodes the port controls, tracks the write strobe, raises the
// illegal-access pulse and drives the broadcast read data.
// Assumes NUM_FLAGS is a power of two and ADDR_W >= log2(NUM_FLAGS).
module semflag_port #(
    parameter int DATA_W    = 18,
    parameter int ADDR_W    = 13,
    parameter int NUM_FLAGS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce_n,
    input  logic                         sem_n,
    input  logic                         rw,
    input  logic                         oe_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_FLAGS-1:0]         view,
    output logic                         commit,
    output logic [$clog2(NUM_FLAGS)-1:0] commit_sel,
    output logic                         commit_val,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rdata_oe,
    output logic                         err
);
    localparam int SEL_W = $clog2(NUM_FLAGS);

    logic [SEL_W-1:0] sel;
    logic             illegal;
    logic             wr_low;
    logic             rd_en;
    logic             armed_q;
    logic             ill_q;
    logic [SEL_W-1:0] cap_sel_q;
    logic             cap_val_q;

    // Decode the access type of this cycle.
    always_comb begin
        sel     = addr[SEL_W-1:0];
        illegal = !sem_n && !ce_n;
        wr_low  = !sem_n && ce_n && !rw;
        rd_en   = !sem_n && ce_n && rw && !oe_n;
    end

    // Track the low phase of the write strobe and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            cap_sel_q <= '0;
            cap_val_q <= 1'b1;
            ill_q     <= 1'b0;
            err       <= 1'b0;
        end else begin
            armed_q <= wr_low;
            if (wr_low) begin
                cap_sel_q <= sel;
                cap_val_q <= wdata[0];
            end
            ill_q <= illegal;
            err   <= illegal && !ill_q;
        end
    end

    // Commit when the strobe returns high on a legal cycle.
    always_comb begin
        commit     = armed_q && rw && !illegal;
        commit_sel = cap_sel_q;
        commit_val = cap_val_q;
    end

    // Broadcast the selected token over the whole bus on a read.
    always_comb begin
        rdata_oe = rd_en;
        rdata    = rd_en ? {DATA_W{view[sel]}} : '0;
    end
endmodule

// File: rtl/semflag_cell.sv
// One token: holder plus one queued-request bit per port.
// Claims and releases arrive already decoded for this token.
// Left wins simultaneous claims on a free token.
module semflag_cell
    import semflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic view_l,
    output logic view_r
);
    owner_e own_q, own_d;
    logic   pend_l_q, pend_l_d;
    logic   pend_r_q, pend_r_d;
    logic   want_l, want_r;

    // Work out the next holder and queue.
    always_comb begin
        want_l   = (pend_l_q || req_l) && !rel_l;
        want_r   = (pend_r_q || req_r) && !rel_r;
        own_d    = own_q;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
        unique case (own_q)
            OWN_LEFT: begin
                if (rel_l) own_d = OWN_NONE;
                pend_r_d = want_r;
            end
            OWN_RIGHT: begin
                if (rel_r) own_d = OWN_NONE;
                pend_l_d = want_l;
            end
            default: begin
                if (want_l) begin
                    own_d    = OWN_LEFT;
                    pend_r_d = want_r;
                end else if (want_r) begin
                    own_d = OWN_RIGHT;
                end
            end
        endcase
    end

    // Hold the token state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= OWN_NONE;
            pend_l_q <= 1'b0;
            pend_r_q <= 1'b0;
        end else begin
            own_q    <= own_d;
            pend_l_q <= pend_l_d;
            pend_r_q <= pend_r_d;
        end
    end

    // A port reads 0 only while it holds the token.
    always_comb begin
        view_l = (own_q != OWN_LEFT);
        view_r = (own_q != OWN_RIGHT);
    end
endmodule

// File: rtl/semflag_unit.sv
// Two-port semaphore token bank.
// Each port reaches the tokens with its semaphore select low and its
// chip select high; the unit resolves claims, releases and queues.
module semflag_unit #(
    parameter int DATA_W    = 18,
    parameter int ADDR_W    = 13,
    parameter int NUM_FLAGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sem_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdata_oe,
    output logic              l_err,
    input  logic              r_ce_n,
    input  logic              r_sem_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdata_oe,
    output logic              r_err
);
    localparam int SEL_W = $clog2(NUM_FLAGS);

    logic                 commit_l, commit_r;
    logic [SEL_W-1:0]     sel_l, sel_r;
    logic                 val_l, val_r;
    logic [NUM_FLAGS-1:0] view_l, view_r;

    semflag_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_port_l (
        .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .sem_n(l_sem_n), .rw(l_rw),
        .oe_n(l_oe_n), .addr(l_addr), .wdata(l_wdata), .view(view_l),
        .commit(commit_l), .commit_sel(sel_l), .commit_val(val_l),
        .rdata(l_rdata), .rdata_oe(l_rdata_oe), .err(l_err)
    );

    semflag_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_port_r (
        .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .sem_n(r_sem_n), .rw(r_rw),
        .oe_n(r_oe_n), .addr(r_addr), .wdata(r_wdata), .view(view_r),
        .commit(commit_r), .commit_sel(sel_r), .commit_val(val_r),
        .rdata(r_rdata), .rdata_oe(r_rdata_oe), .err(r_err)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic hit_l, hit_r;

        // Route each port's commit to the addressed token only.
        always_comb begin
            hit_l = commit_l && (sel_l == SEL_W'(i));
            hit_r = commit_r && (sel_r == SEL_W'(i));
        end

        semflag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(hit_l && !val_l), .rel_l(hit_l && val_l),
            .req_r(hit_r && !val_r), .rel_r(hit_r && val_r),
            .view_l(view_l[i]), .view_r(view_r[i])
        );
    end
endmodule

// File: rtl/semflag_unit_chk.sv
// Property checker for the semaphore unit, bound to the top.
module semflag_unit_chk #(
    parameter int DATA_W    = 18,
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_ce_n,
    input logic                 l_sem_n,
    input logic                 l_rw,
    input logic                 r_ce_n,
    input logic                 r_sem_n,
    input logic                 r_rw,
    input logic                 commit_l,
    input logic                 commit_r,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 l_rdata_oe,
    input logic                 l_err,
    input logic [DATA_W-1:0]    r_rdata,
    input logic                 r_rdata_oe,
    input logic                 r_err,
    input logic [NUM_FLAGS-1:0] view_l,
    input logic [NUM_FLAGS-1:0] view_r
);
    p_reset_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (view_l == '1 && view_r == '1));

    p_commit_armed_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_l |-> $past(!l_rw && !l_sem_n && l_ce_n));

    p_commit_armed_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_r |-> $past(!r_rw && !r_sem_n && r_ce_n));

    p_broadcast_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rdata_oe |-> (l_rdata == '0 || l_rdata == '1));

    p_broadcast_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_rdata_oe |-> (r_rdata == '0 || r_rdata == '1));

    p_quiet_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rdata_oe |-> (l_rdata == '0));

    p_quiet_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rdata_oe |-> (r_rdata == '0));

    p_err_pulse_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l_err |=> !l_err);

    p_err_pulse_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_err |=> !r_err);

    p_no_commit_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sem_n && !l_ce_n) |-> !commit_l);
endmodule

bind semflag_unit semflag_unit_chk #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_rw(l_rw),
    .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_rw(r_rw),
    .commit_l(commit_l), .commit_r(commit_r),
    .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe), .l_err(l_err),
    .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe), .r_err(r_err),
    .view_l(view_l), .view_r(view_r)
);

// File: tb/semflag_unit_bench.sv
// Bench: behavioural reference compared at every falling edge,
// plus directed checks per requirement.
module semflag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n [2];
    logic        sem_n[2];
    logic        rw   [2];
    logic        oe_n [2];
    logic [12:0] addr [2];
    logic [17:0] wdat [2];
    logic [17:0] rdat [2];
    logic        roe  [2];
    logic        err  [2];

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // model state
    int own[8];
    int pl[8];
    int pr[8];
    int armed[2];
    int csel[2];
    int cval[2];
    int illq[2];
    int errq[2];

    always #2.5 clk = ~clk;

    semflag_unit u_semflag_unit (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(ce_n[0]), .l_sem_n(sem_n[0]), .l_rw(rw[0]), .l_oe_n(oe_n[0]),
        .l_addr(addr[0]), .l_wdata(wdat[0]),
        .l_rdata(rdat[0]), .l_rdata_oe(roe[0]), .l_err(err[0]),
        .r_ce_n(ce_n[1]), .r_sem_n(sem_n[1]), .r_rw(rw[1]), .r_oe_n(oe_n[1]),
        .r_addr(addr[1]), .r_wdata(wdat[1]),
        .r_rdata(rdat[1]), .r_rdata_oe(roe[1]), .r_err(err[1])
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Advance the reference by one clock edge.
    task automatic model_step();
        int com[2];
        if (!rst_n) begin
            for (int f = 0; f < 8; f++) begin own[f] = 0; pl[f] = 0; pr[f] = 0; end
            for (int p = 0; p < 2; p++) begin
                armed[p] = 0; csel[p] = 0; cval[p] = 1; illq[p] = 0; errq[p] = 0;
            end
            return;
        end
        for (int p = 0; p < 2; p++)
            com[p] = (armed[p] != 0 && rw[p] && !(!sem_n[p] && !ce_n[p])) ? 1 : 0;
        for (int f = 0; f < 8; f++) begin
            bit ql, ll, qr, lr, wl, wr;
            ql = com[0] != 0 && csel[0] == f && cval[0] == 0;
            ll = com[0] != 0 && csel[0] == f && cval[0] == 1;
            qr = com[1] != 0 && csel[1] == f && cval[1] == 0;
            lr = com[1] != 0 && csel[1] == f && cval[1] == 1;
            wl = (pl[f] != 0 || ql) && !ll;
            wr = (pr[f] != 0 || qr) && !lr;
            if (own[f] == 1) begin
                if (ll) own[f] = 0;
                pl[f] = 0; pr[f] = wr;
            end else if (own[f] == 2) begin
                if (lr) own[f] = 0;
                pr[f] = 0; pl[f] = wl;
            end else if (wl) begin
                own[f] = 1; pl[f] = 0; pr[f] = wr;
            end else if (wr) begin
                own[f] = 2; pl[f] = 0; pr[f] = 0;
            end else begin
                pl[f] = 0; pr[f] = 0;
            end
        end
        for (int p = 0; p < 2; p++) begin
            bit ill, wl2;
            ill = !sem_n[p] && !ce_n[p];
            wl2 = !sem_n[p] && ce_n[p] && !rw[p];
            armed[p] = wl2;
            if (wl2) begin csel[p] = addr[p][2:0]; cval[p] = wdat[p][0]; end
            errq[p] = ill && illq[p] == 0;
            illq[p] = ill;
        end
    endtask

    // One clock: update model on the rise, compare on the fall.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            bit rd;
            logic [17:0] ed;
            rd = !sem_n[p] && ce_n[p] && rw[p] && !oe_n[p];
            ed = (rd && own[addr[p][2:0]] != p + 1) ? '1 : '0;
            check(cur_req, {12'd0, err[p], roe[p], rdat[p]},
                  {12'd0, errq[p][0], rd, ed});
        end
    endtask

    task automatic idle(int p);
        sem_n[p] = 1; ce_n[p] = 1; rw[p] = 1; oe_n[p] = 1;
    endtask

    task automatic arm(int p, logic [12:0] a, bit v);
        sem_n[p] = 0; ce_n[p] = 1; rw[p] = 0; oe_n[p] = 1;
        addr[p] = a; wdat[p] = v ? 18'h2AAA5 : 18'h3FFFE;
    endtask

    task automatic wr(int p, logic [12:0] a, bit v);
        arm(p, a, v); cyc();
        rw[p] = 1; cyc(); idle(p);
    endtask

    task automatic setrd(int p, logic [12:0] a);
        sem_n[p] = 0; ce_n[p] = 1; rw[p] = 1; oe_n[p] = 0; addr[p] = a;
    endtask

    task automatic rd(string req, int p, logic [12:0] a, bit v);
        setrd(p, a); cyc();
        check(req, {13'd0, roe[p], rdat[p]}, {13'd0, 1'b1, v ? 18'h3FFFF : 18'h0});
        idle(p);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        summary();
    end

    initial begin
        for (int p = 0; p < 2; p++) begin idle(p); addr[p] = 0; wdat[p] = 0; end
        rst_n = 0;
        cyc(); cyc(); cyc();
        rst_n = 1;

        // R1: all tokens free after reset
        cur_req = "R1";
        for (int f = 0; f < 8; f++) begin
            rd("R1", 0, 13'(f), 1);
            rd("R1", 1, 13'(f), 1);
        end

        // R5 grant, R2 upper address bits ignored, R3 data bits above 0 ignored
        cur_req = "R5";
        wr(0, 13'h1FF9, 0);
        rd("R5", 0, 13'h0001, 0);
        rd("R2", 1, 13'h0A01, 1);
        rd("R2", 0, 13'h0002, 1);

        // R3: nothing changes during the low phase, commit on return high
        cur_req = "R3";
        arm(1, 13'd4, 0); setrd(0, 13'd4);
        cyc(); cyc(); cyc();
        check("R3", {14'd0, rdat[0]}, {14'd0, 18'h3FFFF});
        rw[1] = 1; cyc();
        check("R3", {14'd0, rdat[0]}, {14'd0, 18'h3FFFF});
        idle(0); idle(1);
        rd("R3", 1, 13'd4, 0);

        // R4: output enable high gives no drive
        cur_req = "R4";
        setrd(1, 13'd4); oe_n[1] = 1; cyc();
        check("R4", {13'd0, roe[1], rdat[1]}, 32'd0);
        idle(1);

        // R6: right queues on token 1, left releases, right gets it a cycle later
        cur_req = "R6";
        wr(1, 13'd1, 0);
        rd("R6", 1, 13'd1, 1);
        arm(0, 13'd1, 1); cyc();
        rw[0] = 1; setrd(1, 13'd1); cyc();
        check("R6", {14'd0, rdat[1]}, {14'd0, 18'h3FFFF});
        idle(0); cyc();
        check("R6", {14'd0, rdat[1]}, 32'd0);
        idle(1);
        rd("R6", 0, 13'd1, 1);

        // R7: left releases token 4 it does not hold
        cur_req = "R7";
        wr(0, 13'd4, 1);
        rd("R7", 1, 13'd4, 0);
        wr(0, 13'd4, 0);          // queue left behind right
        wr(0, 13'd4, 1);          // withdraw queue
        wr(1, 13'd4, 1);          // right releases
        cyc();
        rd("R7", 0, 13'd4, 1);

        // R8: simultaneous claims of token 6
        cur_req = "R8";
        arm(0, 13'd6, 0); arm(1, 13'd6, 0); cyc();
        rw[0] = 1; rw[1] = 1; cyc(); idle(0); idle(1);
        rd("R8", 0, 13'd6, 0);
        rd("R8", 1, 13'd6, 1);
        wr(0, 13'd6, 1); cyc();
        rd("R8", 1, 13'd6, 0);

        // R9: illegal select combination
        cur_req = "R9";
        sem_n[0] = 0; ce_n[0] = 0; cyc();
        check("R9", {31'd0, err[0]}, 32'd1);
        cyc();
        check("R9", {31'd0, err[0]}, 32'd0);
        idle(0); cyc();
        arm(0, 13'd5, 0); cyc();
        ce_n[0] = 0; rw[0] = 1; cyc(); idle(0); cyc();
        rd("R9", 0, 13'd5, 1);

        // R10: strobe abandoned mid-way
        cur_req = "R10";
        arm(0, 13'd7, 0); cyc();
        sem_n[0] = 1; cyc();
        rw[0] = 1; cyc(); idle(0);
        rd("R10", 0, 13'd7, 1);
        rd("R10", 1, 13'd7, 1);

        // Mixed traffic compared every clock
        cur_req = "R6";
        for (int k = 0; k < 3000; k++) begin
            for (int p = 0; p < 2; p++) begin
                int u;
                u = $urandom_range(0, 15);
                sem_n[p] = (u < 13) ? 0 : 1;
                ce_n[p]  = (u == 0) ? 0 : 1;
                rw[p]    = ($urandom_range(0, 2) != 0);
                oe_n[p]  = $urandom_range(0, 1);
                addr[p]  = 13'($urandom);
                wdat[p]  = 18'($urandom);
            end
            cyc();
        end
        idle(0); idle(1); cyc();
        summary();
    end
endmodule